// File: doc/BRIEF.md
# Function-Select 64-bit ALU

This block is a purely combinational arithmetic and logic unit for 64-bit operands. A five-bit function select drives two independent choices. The two low bits decide whether each operand is bitwise complemented before it reaches the logic and arithmetic paths. The three high bits pick which of eight result sources drives the output.

Combining operand complement with the add path gives subtraction and the other two's-complement forms without a separate subtractor. Selecting B complemented, add, and a carry-in of 1 yields A minus B. The two single-position shifts always take the raw A operand. Carry-out always comes from the adder, whichever result source is selected.

Top module: `alu_fsel64`

## Requirements
- R1: When func_sel[0] is 1, every bit of b_in is complemented before the logic and add paths; when it is 0, b_in is used as is.
- R2: When func_sel[1] is 1, every bit of a_in is complemented bitwise (not a one-bit logical NOT) before the logic and add paths.
- R3: func_sel[4:2] = 0 gives the AND, 1 the OR and 3 the XOR of the two conditioned operands.
- R4: func_sel[4:2] = 2 gives the low 64 bits of conditioned A + conditioned B + carry_in.
- R5: func_sel[4:2] = 4 gives raw a_in shifted left by one, with 0 in bit 0. The operand complement select has no effect.
- R6: func_sel[4:2] = 5 gives raw a_in shifted right by one, with 0 in bit 63. The operand complement select has no effect.
- R7: func_sel[4:2] = 6 and 7 both give an all-zero 64-bit result.
- R8: carry_out is bit 64 of conditioned A + conditioned B + carry_in for every value of func_sel[4:2].
- R9: With func_sel[1:0] = 01, func_sel[4:2] = 2 and carry_in = 1, result equals a_in minus b_in modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 64 | Operand A |
| b_in | input | 64 | Operand B |
| carry_in | input | 1 | Carry into the adder |
| func_sel | input | 5 | [1] complement A, [0] complement B, [4:2] result source |
| result | output | 64 | Selected result |
| carry_out | output | 1 | Adder carry out of bit 63 |

## Verification
Both outputs are combinational, so each result is due in the same cycle as the operands and select that produce it, with no register in the path. The driver applies a stimulus one time unit after a rising edge and queues its expected values. The monitor pops and compares them at the following falling edge. Every output has therefore settled before it is sampled, and each comparison is paired with exactly the stimulus that caused it.

// File: rtl/alu_fsel64.sv
module alu_fsel64 #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             carry_in,
  input  logic [4:0]       func_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  logic [WIDTH-1:0] a_cond, b_cond, sum;
  logic [2:0]       op;

  assign op     = func_sel[4:2];
  assign a_cond = func_sel[1] ? ~a_in : a_in;
  assign b_cond = func_sel[0] ? ~b_in : b_in;
  assign {carry_out, sum} = {1'b0, a_cond} + {1'b0, b_cond} + {{WIDTH{1'b0}}, carry_in};

  always_comb begin
    unique case (op)
      3'd0:    result = a_cond & b_cond;
      3'd1:    result = a_cond | b_cond;
      3'd2:    result = sum;
      3'd3:    result = a_cond ^ b_cond;
      3'd4:    result = {a_in[WIDTH-2:0], 1'b0};
      3'd5:    result = {1'b0, a_in[WIDTH-1:1]};
      default: result = '0;
    endcase
  end
endmodule

module alu_fsel64_chk #(
  parameter int WIDTH = 64
) (
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic             carry_in,
  input logic [4:0]       func_sel,
  input logic [WIDTH-1:0] result,
  input logic             carry_out
);
  always_comb begin
    if (func_sel[4:2] == 3'd0 && func_sel[1:0] == 2'b00)
      assert_and_subset_R3: assert ((result & ~a_in) == '0 && (result & ~b_in) == '0);
    if (func_sel[4:2] == 3'd3 && func_sel[1] == 1'b0)
      assert_xor_binv_R1: assert ((result ^ a_in) == (func_sel[0] ? ~b_in : b_in));
    if (func_sel[4:2] == 3'd3 && func_sel[0] == 1'b0)
      assert_xor_ainv_R2: assert ((result ^ b_in) == (func_sel[1] ? ~a_in : a_in));
    if (func_sel[4:2] == 3'd4)
      assert_shl_raw_R5: assert (result[0] == 1'b0 && (result >> 1) == {1'b0, a_in[WIDTH-2:0]});
    if (func_sel[4:2] == 3'd5)
      assert_shr_raw_R6: assert (result[WIDTH-1] == 1'b0 && (result << 1) == {a_in[WIDTH-1:1], 1'b0});
    if (func_sel[4:3] == 2'b11)
      assert_zero_src_R7: assert (result == '0);
    if (func_sel[1:0] == 2'b00 && !carry_in)
      assert_carry_any_op_R8: assert (carry_out == ((a_in + b_in) < a_in));
    if (func_sel == 5'b01001 && carry_in)
      assert_sub_R9: assert (result == a_in - b_in);
  end
endmodule

bind alu_fsel64 alu_fsel64_chk #(.WIDTH(WIDTH)) u_chk (
  .a_in(a_in), .b_in(b_in), .carry_in(carry_in), .func_sel(func_sel),
  .result(result), .carry_out(carry_out)
);

// File: tb/alu_fsel64_tb.sv
module alu_fsel64_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] a_in = '0, b_in = '0;
  logic        carry_in = 1'b0;
  logic [4:0]  func_sel = '0;
  logic [63:0] result;
  logic        carry_out;
  int          checks = 0, fails = 0, cycles = 0;
  bit          done = 1'b0;

  logic [64:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  alu_fsel64 u_dut (
    .a_in(a_in), .b_in(b_in), .carry_in(carry_in), .func_sel(func_sel),
    .result(result), .carry_out(carry_out)
  );

  function automatic logic [64:0] model(logic [63:0] a, logic [63:0] b, logic ci, logic [4:0] fs);
    logic [63:0] ac, bc, r;
    logic [64:0] s;
    ac = a; bc = b;
    for (int i = 0; i < 64; i++) begin
      if (fs[1]) ac[i] = ~a[i];
      if (fs[0]) bc[i] = ~b[i];
    end
    s = {1'b0, ac} + {1'b0, bc} + 65'(ci);
    case (fs[4:2])
      3'd0: r = ac & bc;
      3'd1: r = ac | bc;
      3'd2: r = s[63:0];
      3'd3: r = ac ^ bc;
      3'd4: r = a * 64'd2;
      3'd5: r = a / 64'd2;
      default: r = 64'd0;
    endcase
    return {s[64], r};
  endfunction

  task automatic apply(logic [63:0] a, logic [63:0] b, logic ci, logic [4:0] fs, string tag);
    @(posedge clk);
    #1;
    a_in = a; b_in = b; carry_in = ci; func_sel = fs;
    exp_q.push_back(model(a, b, ci, fs));
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [64:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({carry_out, result} !== e) begin
        fails++;
        $display("FAIL %s: got co=%0b res=%h, expected co=%0b res=%h", t, carry_out, result, e[64], e[63:0]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: got cycles=%0d, expected finish", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    apply('0, '0, 1'b0, 5'b00000, "R3 idle zero");
    apply(64'hF0F0_0000_FFFF_1234, 64'hFF00_FF00_0F0F_00FF, 1'b0, 5'b00000, "R3 and");
    apply(64'hF0F0_0000_FFFF_1234, 64'hFF00_FF00_0F0F_00FF, 1'b0, 5'b00100, "R3 or");
    apply(64'hF0F0_0000_FFFF_1234, 64'hFF00_FF00_0F0F_00FF, 1'b0, 5'b01100, "R3 xor");
    apply(64'h0123_4567_89AB_CDEF, 64'h0, 1'b0, 5'b00001, "R1 and with ~b");
    apply(64'h0123_4567_89AB_CDEF, 64'h1, 1'b0, 5'b00110, "R2 or with ~a");
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 5'b01000, "R4 R8 wrap carry");
    apply(64'h7FFF_FFFF_FFFF_FFFE, 64'h1, 1'b1, 5'b01000, "R4 carry in");
    apply(64'd1000, 64'd1, 1'b1, 5'b01001, "R9 sub");
    apply(64'd5, 64'd9, 1'b1, 5'b01001, "R9 sub borrow");
    apply(64'd7, 64'd7, 1'b1, 5'b01001, "R9 sub equal carry");
    apply(64'h8000_0000_0000_0001, 64'h0, 1'b0, 5'b10000, "R5 shl");
    apply(64'h8000_0000_0000_0001, 64'h0, 1'b0, 5'b10011, "R5 shl raw a");
    apply(64'h8000_0000_0000_0001, 64'h0, 1'b0, 5'b10100, "R6 shr");
    apply(64'h8000_0000_0000_0001, 64'h0, 1'b0, 5'b10110, "R6 shr raw a");
    apply('1, '1, 1'b1, 5'b11000, "R7 zero op6");
    apply('1, '1, 1'b1, 5'b11111, "R7 zero op7");
    apply('1, 64'h1, 1'b0, 5'b11100, "R8 carry under op7");
    apply('1, 64'h1, 1'b0, 5'b00000, "R8 carry under and");
    for (int i = 0; i < 400; i++) begin
      logic [4:0] fs;
      fs = 5'($urandom_range(0, 31));
      apply({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), fs,
            (fs[4:2] == 3'd2) ? "R4 R8 sweep" : (fs[4:2] >= 3'd6) ? "R7 sweep" :
            (fs[4:2] >= 3'd4) ? "R5 R6 sweep" : "R1 R2 R3 sweep");
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule